// File: doc/BRIEF.md
# Frame Byte Counter with Limit Interrupt

This block keeps the running byte count of the frame that a wireless LAN MAC is currently sending or receiving. The transmit and receive paths share one 12-bit counter, and each direction applies its own counting rule. On the transmit side the count starts after the start-of-frame delimiter goes out, and bytes sent during the CRC phase are left out. On the receive side every byte written into the receive FIFO after the delimiter is detected is counted, and that includes PHY-header and CRC bytes. A new delimiter in either direction clears the count and selects that direction. An end-of-frame pulse returns the block to idle, and the count then holds its last value.

Software programs a 12-bit limit. Once per frame, when the count of the active direction equals a nonzero limit, the block latches a status bit for that direction, provided the direction's mask bit is clear. The latched bit drives that direction's interrupt pin until software writes 1 to clear it. The limit only raises interrupts. It never gates the byte strobes or the framing logic around the block. Access goes through a small 8-bit register port with registered read data.

Top module: `frame_byte_counter`

## Requirements
- R1: After reset the count, the limit, the interrupt status bits and the mask bits are all zero, and both interrupt pins are low.
- R2: A pulse on `tx_sfd_done` clears the count to zero and selects transmit. From then on each cycle with `tx_byte` high adds one, as long as `tx_crc_phase` is low.
- R3: While transmit is selected, `tx_byte` cycles with `tx_crc_phase` high leave the count unchanged.
- R4: A pulse on `rx_sfd_det` clears the count and selects receive. Each `rx_fifo_wr` cycle then adds one, whatever the level of `tx_crc_phase`. Strobes of the direction that is not selected are ignored. If both delimiter pulses arrive in the same cycle, transmit wins.
- R5: After a `frame_end` pulse, and before the first delimiter after reset, byte strobes are ignored and the count keeps its value.
- R6: Register map, selected by `reg_addr`: 0 holds count bits 7:0. 1 holds count bits 11:8 in bits 3:0, and its bits 7:4 read 0. 2 holds limit bits 7:0 (read/write). 3 holds limit bits 11:8 in bits 3:0 (read/write). 4 is interrupt status, with bit 0 for transmit and bit 1 for receive. 5 is the mask, with bit 0 for transmit and bit 1 for receive. A `reg_rd` cycle makes `reg_rdata` valid after the next clock edge. Writes to addresses 0 and 1 have no effect.
- R7: The count saturates at 4095 and does not wrap.
- R8: When the count register equals a nonzero limit while a direction is selected, that direction's status bit sets one clock later, and `irq_tx` or `irq_rx` follows it. The other direction's bit stays clear.
- R9: A match while a direction's mask bit is 1 does not set its status bit.
- R10: Writing 1 to a status bit clears it. A set on the same cycle takes priority. Each direction fires at most once per frame, including after a clear or a change of the limit, and the next delimiter re-arms it.
- R11: A limit of zero never raises an interrupt.
- R12: A limit write takes effect at once. If the limit is written to equal the current count mid-frame, the interrupt fires one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_sfd_done | input | 1 | Transmit delimiter has been sent; starts a transmit frame |
| tx_byte | input | 1 | One byte sent by the transmit serializer |
| tx_crc_phase | input | 1 | Transmit bytes now belong to the CRC |
| rx_sfd_det | input | 1 | Receive delimiter detected; starts a receive frame |
| rx_fifo_wr | input | 1 | One byte written into the receive FIFO |
| frame_end | input | 1 | Current frame has finished |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_tx | output | 1 | Transmit byte-count interrupt |
| irq_rx | output | 1 | Receive byte-count interrupt |

## Verification
The bench walks through the CRC window, checking that a design which counted CRC bytes would reach the limit two bytes early, and that one which excluded them on receive would miss a limit that only the CRC reaches. It clears a fired status and then raises the limit onto the next count within the same frame, so a design without a per-frame fired flag would interrupt twice. It also writes a limit of zero into a freshly cleared frame, where a design that did not exclude zero would interrupt at once. Finally it runs a receive burst past 4095, where a wrapping counter would read back a small value, and it reads the reserved high nibble, which a sloppy read mux would fill with limit or garbage bits.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

   typedef enum logic [1:0] {
      DIR_IDLE = 2'd0,
      DIR_TX   = 2'd1,
      DIR_RX   = 2'd2
   } dir_e;

   localparam int unsigned N_DIR  = 2;
   localparam int unsigned IDX_TX = 0;
   localparam int unsigned IDX_RX = 1;

   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
   localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd2;
   localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd3;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
   localparam logic [ADDR_W-1:0] A_MASK   = 3'd5;

endpackage

// File: rtl/fbc_frame_track.sv
module fbc_frame_track
   import fbc_pkg::*;
#(
   parameter bit TX_SKIP_CRC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_sfd_done,
   input  logic tx_byte,
   input  logic tx_crc_phase,
   input  logic rx_sfd_det,
   input  logic rx_fifo_wr,
   input  logic frame_end,
   output dir_e dir,
   output logic frame_start,
   output logic count_en
);

   logic tx_take;

   generate
      if (TX_SKIP_CRC) begin : g_tx_skip_crc
         assign tx_take = tx_byte & ~tx_crc_phase;
      end else begin : g_tx_all
         assign tx_take = tx_byte;
      end
   endgenerate

   assign frame_start = tx_sfd_done | rx_sfd_det;

   always_comb begin
      unique case (dir)
         DIR_TX:  count_en = tx_take;
         DIR_RX:  count_en = rx_fifo_wr;
         default: count_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= DIR_IDLE;
      end else if (tx_sfd_done) begin
         dir <= DIR_TX;
      end else if (rx_sfd_det) begin
         dir <= DIR_RX;
      end else if (frame_end) begin
         dir <= DIR_IDLE;
      end
   end

   // R4: receive delimiter alone selects the receive direction
   a_r4_rx_select: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_sfd_det && !tx_sfd_done) |=> (dir == DIR_RX));

   // R2: transmit delimiter always selects transmit
   a_r2_tx_select: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sfd_done |=> (dir == DIR_TX));

   // R5: frame end without a new delimiter returns to idle
   a_r5_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !frame_start) |=> (dir == DIR_IDLE));

endmodule

// File: rtl/fbc_counter.sv
module fbc_counter #(
   parameter int unsigned CNT_W    = 12,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count_inc;

   generate
      if (SATURATE) begin : g_sat
         assign count_inc = (count == CNT_MAX) ? count : count + 1'b1;

         // R7: the count holds at its ceiling
         a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (count == CNT_MAX && !clr) |=> (count == CNT_MAX));
      end else begin : g_wrap
         assign count_inc = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (en) begin
         count <= count_inc;
      end
   end

   // R2: a clear leaves zero behind
   a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

   // R5: with no enable and no clear the count is frozen
   a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(count));

endmodule

// File: rtl/fbc_limit_irq.sv
module fbc_limit_irq #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             arm,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] limit,
   input  logic             mask,
   input  logic             clr_w1c,
   output logic             status
);

   logic fired;
   logic hit;

   assign hit = active & ~arm & ~fired & (limit != '0) & (count == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired <= 1'b0;
      end else if (arm) begin
         fired <= 1'b0;
      end else if (hit) begin
         fired <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
      end else if (hit && !mask) begin
         status <= 1'b1;
      end else if (clr_w1c) begin
         status <= 1'b0;
      end
   end

   // R9: a masked direction never latches a new status
   a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && !status) |=> !status);

   // R11: a zero limit never latches a new status
   a_r11_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0 && !status) |=> !status);

   // R10: once fired in a frame, no second set before re-arming
   a_r10_once: assert property (@(posedge clk) disable iff (!rst_n)
      (fired && !arm && !status) |=> !status);

   // R10: a clear with no match drops the status
   a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w1c && !active) |=> !status);

endmodule

// File: rtl/fbc_regif.sv
module fbc_regif
   import fbc_pkg::*;
#(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic [N_DIR-1:0]  status,
   output logic [CNT_W-1:0]  limit,
   output logic [N_DIR-1:0]  mask,
   output logic [N_DIR-1:0]  clr_w1c,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int unsigned HI_W = CNT_W - DATA_W;

   logic [DATA_W-1:0] rd_mux;

   assign clr_w1c = (reg_wr && reg_addr == A_STAT) ? reg_wdata[N_DIR-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= '0;
         mask  <= '0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            A_LIM_LO: limit[DATA_W-1:0]     <= reg_wdata;
            A_LIM_HI: limit[CNT_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
            A_MASK:   mask                  <= reg_wdata[N_DIR-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      unique case (reg_addr)
         A_CNT_LO: rd_mux = count[DATA_W-1:0];
         A_CNT_HI: rd_mux = DATA_W'(count >> DATA_W);
         A_LIM_LO: rd_mux = limit[DATA_W-1:0];
         A_LIM_HI: rd_mux = DATA_W'(limit >> DATA_W);
         A_STAT:   rd_mux = DATA_W'(status);
         A_MASK:   rd_mux = DATA_W'(mask);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         reg_rdata <= rd_mux;
      end
   end

   // R6: reserved high-nibble bits of the count read as zero
   a_r6_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_CNT_HI) |=> (reg_rdata[DATA_W-1:HI_W] == '0));

   // R12: a low-limit write is visible on the next cycle
   a_r12_limit_now: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_LIM_LO) |=> (limit[DATA_W-1:0] == $past(reg_wdata)));

endmodule

// File: rtl/frame_byte_counter.sv
module frame_byte_counter
   import fbc_pkg::*;
#(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned DATA_W      = 8,
   parameter bit          SATURATE    = 1'b1,
   parameter bit          TX_SKIP_CRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_sfd_done,
   input  logic              tx_byte,
   input  logic              tx_crc_phase,
   input  logic              rx_sfd_det,
   input  logic              rx_fifo_wr,
   input  logic              frame_end,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq_tx,
   output logic              irq_rx
);

   generate
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must exceed DATA_W and fit in two register bytes");
      end
      if (DATA_W != 8) begin : g_bad_data_w
         $error("register port is fixed at eight bits");
      end
   endgenerate

   dir_e             dir;
   logic             frame_start;
   logic             count_en;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] limit;
   logic [N_DIR-1:0] mask;
   logic [N_DIR-1:0] clr_w1c;
   logic [N_DIR-1:0] status;
   logic [N_DIR-1:0] dir_act;

   fbc_frame_track #(
      .TX_SKIP_CRC (TX_SKIP_CRC)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_sfd_done  (tx_sfd_done),
      .tx_byte      (tx_byte),
      .tx_crc_phase (tx_crc_phase),
      .rx_sfd_det   (rx_sfd_det),
      .rx_fifo_wr   (rx_fifo_wr),
      .frame_end    (frame_end),
      .dir          (dir),
      .frame_start  (frame_start),
      .count_en     (count_en)
   );

   fbc_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_start),
      .en    (count_en),
      .count (count)
   );

   assign dir_act[IDX_TX] = (dir == DIR_TX);
   assign dir_act[IDX_RX] = (dir == DIR_RX);

   for (genvar d = 0; d < N_DIR; d++) begin : g_irq
      fbc_limit_irq #(
         .CNT_W (CNT_W)
      ) u_irq (
         .clk     (clk),
         .rst_n   (rst_n),
         .active  (dir_act[d]),
         .arm     (frame_start),
         .count   (count),
         .limit   (limit),
         .mask    (mask[d]),
         .clr_w1c (clr_w1c[d]),
         .status  (status[d])
      );
   end

   fbc_regif #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .count     (count),
      .status    (status),
      .limit     (limit),
      .mask      (mask),
      .clr_w1c   (clr_w1c),
      .reg_rdata (reg_rdata)
   );

   assign irq_tx = status[IDX_TX];
   assign irq_rx = status[IDX_RX];

   // R3: CRC-phase transmit bytes leave the count alone
   a_r3_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_TX && tx_crc_phase && !tx_sfd_done && !rx_sfd_det) |=> $stable(count));

   // R5: idle direction ignores all byte strobes
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_IDLE && !tx_sfd_done && !rx_sfd_det) |=> $stable(count));

   // R4: receive frames ignore transmit byte strobes
   a_r4_rx_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == DIR_RX && !rx_fifo_wr && !tx_sfd_done && !rx_sfd_det) |=> $stable(count));

   // R8: an interrupt pin rises only for the direction in progress
   a_r8_tx_only_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (dir != DIR_TX) |=> !$rose(irq_tx));

   a_r8_rx_only_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (dir != DIR_RX) |=> !$rose(irq_rx));

endmodule

// File: tb/frame_byte_counter_test.sv
module frame_byte_counter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_sfd_done = 1'b0;
   logic       tx_byte = 1'b0;
   logic       tx_crc_phase = 1'b0;
   logic       rx_sfd_det = 1'b0;
   logic       rx_fifo_wr = 1'b0;
   logic       frame_end = 1'b0;
   logic       reg_rd = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq_tx;
   logic       irq_rx;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   logic rd_pend = 1'b0;

   always #4 clk = ~clk;

   frame_byte_counter uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_sfd_done  (tx_sfd_done),
      .tx_byte      (tx_byte),
      .tx_crc_phase (tx_crc_phase),
      .rx_sfd_det   (rx_sfd_det),
      .rx_fifo_wr   (rx_fifo_wr),
      .frame_end    (frame_end),
      .reg_rd       (reg_rd),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .irq_tx       (irq_tx),
      .irq_rx       (irq_rx)
   );

   // monitor: compare each registered read with the queued expectation
   always @(posedge clk) rd_pend <= reg_rd;

   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: read with no expectation, got %02h", reg_rdata);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (reg_rdata !== e.val) begin
               errors++;
               $display("FAIL %s: read %02h expected %02h", e.tag, reg_rdata, e.val);
            end
         end
      end
   end

   task automatic rd_expect(input logic [2:0] a, input logic [7:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
      reg_addr = a;
      reg_rd   = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = v;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pin_check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pin %b expected %b", tag, act, exp);
      end
   endtask

   task automatic pulse_tx_sfd();
      @(negedge clk);
      tx_sfd_done = 1'b1;
      @(negedge clk);
      tx_sfd_done = 1'b0;
   endtask

   task automatic pulse_rx_sfd();
      @(negedge clk);
      rx_sfd_det = 1'b1;
      @(negedge clk);
      rx_sfd_det = 1'b0;
   endtask

   task automatic pulse_end();
      @(negedge clk);
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
   endtask

   task automatic send_tx(input int n);
      @(negedge clk);
      tx_byte = 1'b1;
      repeat (n) @(negedge clk);
      tx_byte = 1'b0;
   endtask

   task automatic send_rx(input int n);
      @(negedge clk);
      rx_fifo_wr = 1'b1;
      repeat (n) @(negedge clk);
      rx_fifo_wr = 1'b0;
   endtask

   task automatic set_limit(input int v);
      wr(3'd3, 8'(v >> 8));
      wr(3'd2, 8'(v));
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d reads never returned", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      pin_check(irq_tx, 1'b0, "R1 irq_tx");
      pin_check(irq_rx, 1'b0, "R1 irq_rx");
      rd_expect(3'd0, 8'h00, "R1 count lo");
      rd_expect(3'd1, 8'h00, "R1 count hi");
      rd_expect(3'd2, 8'h00, "R1 limit lo");
      rd_expect(3'd3, 8'h00, "R1 limit hi");
      rd_expect(3'd4, 8'h00, "R1 status");
      rd_expect(3'd5, 8'h00, "R1 mask");

      // R5: strobes before any delimiter are ignored
      send_tx(3);
      send_rx(3);
      rd_expect(3'd0, 8'h00, "R5 pre-frame count");

      // R6: register map, count is read-only, limit high nibble only
      wr(3'd0, 8'hAA);
      wr(3'd1, 8'h0F);
      rd_expect(3'd0, 8'h00, "R6 count lo write ignored");
      rd_expect(3'd1, 8'h00, "R6 count hi write ignored");
      wr(3'd3, 8'hF7);
      rd_expect(3'd3, 8'h07, "R6 limit hi nibble");
      set_limit(5);
      rd_expect(3'd2, 8'h05, "R6 limit lo");
      rd_expect(3'd3, 8'h00, "R6 limit hi");

      // R2/R3/R8: transmit frame, CRC bytes excluded
      pulse_tx_sfd();
      send_tx(3);
      rd_expect(3'd0, 8'h03, "R2 tx count");
      tx_crc_phase = 1'b1;
      send_tx(2);
      tx_crc_phase = 1'b0;
      rd_expect(3'd0, 8'h03, "R3 crc bytes skipped");
      pin_check(irq_tx, 1'b0, "R3 no early irq");
      send_tx(2);
      pin_check(irq_tx, 1'b0, "R8 status lags count by one clock");
      @(negedge clk);
      pin_check(irq_tx, 1'b1, "R8 irq_tx at limit");
      pin_check(irq_rx, 1'b0, "R8 irq_rx stays low in tx");
      rd_expect(3'd4, 8'h01, "R8 status tx bit");

      // R4: receive strobe ignored during transmit
      send_rx(2);
      rd_expect(3'd0, 8'h05, "R4 rx strobe ignored in tx");

      // R5: frame end freezes the count
      pulse_end();
      send_tx(4);
      rd_expect(3'd0, 8'h05, "R5 count holds after end");
      pin_check(irq_tx, 1'b1, "R10 status stays latched");

      // R10: write-one-to-clear
      wr(3'd4, 8'h01);
      pin_check(irq_tx, 1'b0, "R10 w1c clears tx");

      // R10: once per frame, re-armed by the next delimiter
      set_limit(2);
      pulse_tx_sfd();
      send_tx(2);
      @(negedge clk);
      pin_check(irq_tx, 1'b1, "R10 fires at 2");
      wr(3'd4, 8'h01);
      set_limit(3);
      send_tx(1);
      @(negedge clk);
      @(negedge clk);
      pin_check(irq_tx, 1'b0, "R10 no second fire in frame");
      rd_expect(3'd0, 8'h03, "R10 count reached new limit");
      pulse_tx_sfd();
      send_tx(3);
      @(negedge clk);
      pin_check(irq_tx, 1'b1, "R10 re-armed by new delimiter");
      wr(3'd4, 8'h01);
      pulse_end();

      // R4/R8: receive frame counts every FIFO write, CRC flag ignored
      set_limit(260);
      pulse_rx_sfd();
      tx_crc_phase = 1'b1;
      send_tx(2);
      send_rx(260);
      tx_crc_phase = 1'b0;
      rd_expect(3'd0, 8'h04, "R4 rx count lo");
      rd_expect(3'd1, 8'h01, "R4 rx count hi");
      pin_check(irq_rx, 1'b1, "R8 irq_rx at limit");
      pin_check(irq_tx, 1'b0, "R8 irq_tx low in rx");
      rd_expect(3'd4, 8'h02, "R8 status rx bit");
      wr(3'd4, 8'h02);
      pin_check(irq_rx, 1'b0, "R10 w1c clears rx");
      pulse_end();

      // R9: masked receive match leaves status clear
      wr(3'd5, 8'h02);
      rd_expect(3'd5, 8'h02, "R6 mask readback");
      set_limit(3);
      pulse_rx_sfd();
      send_rx(3);
      @(negedge clk);
      pin_check(irq_rx, 1'b0, "R9 masked no irq");
      rd_expect(3'd4, 8'h00, "R9 masked status clear");
      wr(3'd5, 8'h00);
      @(negedge clk);
      pin_check(irq_rx, 1'b0, "R9 unmask after match stays quiet");
      pulse_end();

      // R11: zero limit never fires, even with count zero
      set_limit(0);
      pulse_tx_sfd();
      repeat (3) @(negedge clk);
      pin_check(irq_tx, 1'b0, "R11 zero limit quiet");
      rd_expect(3'd4, 8'h00, "R11 status clear");
      pulse_end();

      // R12: limit write takes effect at once
      set_limit(20);
      pulse_rx_sfd();
      send_rx(10);
      @(negedge clk);
      pin_check(irq_rx, 1'b0, "R12 below limit");
      wr(3'd2, 8'd10);
      pin_check(irq_rx, 1'b0, "R12 one clock after write not yet");
      @(negedge clk);
      pin_check(irq_rx, 1'b1, "R12 fires after limit write");
      wr(3'd4, 8'h02);
      pulse_end();

      // R7: saturation at 4095, reserved bits read zero
      wr(3'd5, 8'h03);
      pulse_rx_sfd();
      send_rx(4100);
      rd_expect(3'd0, 8'hFF, "R7 saturated lo");
      rd_expect(3'd1, 8'h0F, "R7 saturated hi, R6 reserved zero");
      send_rx(5);
      rd_expect(3'd0, 8'hFF, "R7 stays saturated");

      // R2: a new delimiter clears a saturated count
      pulse_tx_sfd();
      rd_expect(3'd0, 8'h00, "R2 delimiter clears count lo");
      rd_expect(3'd1, 8'h00, "R2 delimiter clears count hi");

      finish_run();
   end

endmodule